// File: doc/BRIEF.md
# Single-Wire Sync Responder

This block sits on the target side of a one-wire, open-drain debug line and runs on the target's own communication clock. It watches the synchronized pin value for a synchronization request. A request is a low time far longer than any pulse that ordinary bit traffic produces. When it sees a request, it answers with a reply pulse of fixed length. The host measures that pulse to learn the target's clock rate.

After a request, the block waits for the host to let the line go high. It then holds off for a guard interval so that the host's own speedup pulse can finish. Next it pulls the line low for a fixed number of its own cycles, drives a single active-high speedup cycle to give a sharp rising edge, and then releases the pin to high impedance. A one-cycle status pulse marks that release. If another driver pulls the line low during the guard interval, the reply is abandoned. The active-low reset returns the block to idle at any moment.

The pin interface is a pair of signals: an output enable and an output value. Both come straight from flops, so the pad sees no combinational glitches.

Top module: `sync_responder`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, drive_en, drive_val and reply_done are all 0.
- R2: A low run of DETECT_CYCLES-1 consecutive sampled cycles (default 127) is ignored: the block never drives the pin and reply_done stays 0.
- R3: A low run of exactly DETECT_CYCLES consecutive sampled cycles (default 128) is taken as a request and produces a complete reply.
- R4: After a request, the block keeps the pin released for as long as the line stays low, however long that is.
- R5: After the line has returned high, the pin stays released for exactly GUARD_CYCLES cycles (default 16) before driving starts.
- R6: The reply drives the pin low (drive_en=1, drive_val=0) for exactly LOW_CYCLES consecutive cycles (default 128).
- R7: Directly after the low phase, the block drives the pin high (drive_en=1, drive_val=1) for exactly one cycle.
- R8: In the cycle after the speedup cycle, drive_en returns to 0 and reply_done is 1 for that single cycle only.
- R9: The low-run count is cleared by any high cycle. Two low runs of DETECT_CYCLES-1 cycles separated by one high cycle produce no reply.
- R10: A low sample during the guard interval, including its final cycle, cancels the reply. No drive and no reply_done follow. A later fresh request is answered normally.
- R11: Asserting reset during a reply releases the pin at once, with no clock edge needed, and no reply follows the reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Communication clock of the target |
| rst_n | input | 1 | Asynchronous active-low reset to idle |
| line_in | input | 1 | Synchronized value of the debug line (1 = high) |
| drive_en | output | 1 | Pin output enable; 0 leaves the pin high impedance |
| drive_val | output | 1 | Value driven on the pin when drive_en is 1 |
| reply_done | output | 1 | One-cycle pulse when the pin is released after a reply |

## Verification
Two things can land in the same cycle: the guard timer expiring, which starts the drive, and a low sample on the line, which cancels the reply. The cancel must take priority. The bench provokes this by releasing the line and then pulling it low for one cycle, timed so that the low value is sampled at the very edge where the guard count runs out. It then judges that drive_en never rises and reply_done never pulses. A later clean request must still get a full reply.

// File: rtl/sync_resp_pkg.sv
package sync_resp_pkg;

    typedef enum logic [2:0] {
        SR_IDLE  = 3'd0,
        SR_ARMED = 3'd1,
        SR_GUARD = 3'd2,
        SR_LOW   = 3'd3,
        SR_KICK  = 3'd4
    } sr_state_e;

    typedef struct packed {
        sr_state_e state;
        logic      drive_en;
        logic      drive_val;
        logic      done;
    } sr_regs_t;

    localparam sr_regs_t SR_RESET = '{state: SR_IDLE, drive_en: 1'b0,
                                      drive_val: 1'b0, done: 1'b0};

endpackage

// File: rtl/sync_low_meter.sv
module sync_low_meter #(
    parameter int unsigned THRESH = 128
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_in,
    output logic req_hit
);
    localparam int unsigned CW   = (THRESH > 1) ? $clog2(THRESH) : 1;
    localparam int unsigned TOPV = THRESH - 1;

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d   = cnt_q;
        req_hit = 1'b0;
        if (line_in) begin
            cnt_d = '0;
        end else if (cnt_q == CW'(TOPV)) begin
            req_hit = 1'b1;
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/sync_phase_timer.sv
module sync_phase_timer #(
    parameter int unsigned MAXV = 128,
    localparam int unsigned TW  = $clog2(MAXV + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [TW-1:0] load_val,
    output logic          last
);
    logic [TW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)                 cnt_d = load_val;
        else if (cnt_q != '0)     cnt_d = cnt_q - 1'b1;
        last = (cnt_q == TW'(1));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/sync_responder.sv
module sync_responder #(
    parameter int unsigned DETECT_CYCLES = 128,
    parameter int unsigned GUARD_CYCLES  = 16,
    parameter int unsigned LOW_CYCLES    = 128
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_in,
    output logic drive_en,
    output logic drive_val,
    output logic reply_done
);
    import sync_resp_pkg::*;

    localparam int unsigned TMAX = (GUARD_CYCLES > LOW_CYCLES) ? GUARD_CYCLES : LOW_CYCLES;
    localparam int unsigned TW   = $clog2(TMAX + 1);

    sr_regs_t      r_d, r_q;
    logic          req_hit;
    logic          tmr_last;
    logic          tmr_load;
    logic [TW-1:0] tmr_val;

    sync_low_meter #(.THRESH(DETECT_CYCLES)) u_meter (
        .clk     (clk),
        .rst_n   (rst_n),
        .line_in (line_in),
        .req_hit (req_hit)
    );

    sync_phase_timer #(.MAXV(TMAX)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .last     (tmr_last)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (r_q.state)
            SR_IDLE: begin
                if (req_hit) r_d.state = SR_ARMED;
            end
            SR_ARMED: begin
                if (line_in) begin
                    r_d.state = SR_GUARD;
                    tmr_load  = 1'b1;
                    tmr_val   = TW'(GUARD_CYCLES);
                end
            end
            SR_GUARD: begin
                // a foreign low outranks guard expiry
                if (!line_in) begin
                    r_d.state = SR_IDLE;
                end else if (tmr_last) begin
                    r_d.state = SR_LOW;
                    tmr_load  = 1'b1;
                    tmr_val   = TW'(LOW_CYCLES);
                end
            end
            SR_LOW: begin
                if (tmr_last) r_d.state = SR_KICK;
            end
            SR_KICK: begin
                r_d.state = SR_IDLE;
                r_d.done  = 1'b1;
            end
            default: r_d.state = SR_IDLE;
        endcase
        r_d.drive_en  = (r_d.state == SR_LOW) || (r_d.state == SR_KICK);
        r_d.drive_val = (r_d.state == SR_KICK);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= SR_RESET;
        else        r_q <= r_d;
    end

    assign drive_en   = r_q.drive_en;
    assign drive_val  = r_q.drive_val;
    assign reply_done = r_q.done;
endmodule

// File: rtl/sync_responder_chk.sv
module sync_responder_chk (
    input logic clk,
    input logic rst_n,
    input logic line_in,
    input logic drive_en,
    input logic drive_val,
    input logic reply_done
);
    // R7: high speedup lasts a single cycle, then the pin is released
    assert_kick_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (drive_en && drive_val) |=> !drive_en);

    // R7: the speedup cycle always follows a low-drive cycle
    assert_kick_after_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(drive_val) |-> $past(drive_en && !drive_val));

    // R8: completion pulse only right after a speedup cycle
    assert_done_after_kick_R8: assert property (@(posedge clk) disable iff (!rst_n)
        reply_done |-> ($past(drive_en && drive_val) && !drive_en));

    // R8: completion pulse is one cycle wide
    assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        reply_done |=> !reply_done);

    // R5: driving begins only after a cycle with the line high (end of guard)
    assert_drive_after_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(drive_en) |-> $past(line_in));

    // R6: value never high without enable
    assert_val_needs_en_R6: assert property (@(posedge clk) disable iff (!rst_n)
        drive_val |-> drive_en);
endmodule

bind sync_responder sync_responder_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .line_in    (line_in),
    .drive_en   (drive_en),
    .drive_val  (drive_val),
    .reply_done (reply_done)
);

// File: tb/sync_responder_tb.sv
module sync_responder_tb;
    localparam int DET = 128;
    localparam int GRD = 16;
    localparam int LOW = 128;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic host_low = 1'b0;
    logic line_in;
    logic drive_en, drive_val, reply_done;
    int   n_chk = 0;
    int   n_bad = 0;
    bit   finished = 1'b0;

    always #4 clk = ~clk;

    // open-drain line: low if anyone pulls it low
    assign line_in = ~(host_low | (drive_en & ~drive_val));

    sync_responder #(.DETECT_CYCLES(DET), .GUARD_CYCLES(GRD), .LOW_CYCLES(LOW)) u_dut (
        .clk(clk), .rst_n(rst_n), .line_in(line_in),
        .drive_en(drive_en), .drive_val(drive_val), .reply_done(reply_done)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic hold_low(input int n);
        host_low = 1'b1;
        repeat (n) @(negedge clk);
        host_low = 1'b0;
    endtask

    task automatic expect_quiet(input int n, input string tag);
        bit ok = 1'b1;
        int hits = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (drive_en || reply_done) begin ok = 1'b0; hits++; end
        end
        check(ok, tag, hits, 0);
    endtask

    task automatic measure_reply(input string tag);
        int g = 0;
        int w = 0;
        @(negedge clk);
        while (!drive_en && g < 400) begin g++; @(negedge clk); end
        check(g == GRD, {tag, " R5 guard length"}, g, GRD);
        while (drive_en && !drive_val && w < 400) begin w++; @(negedge clk); end
        check(w == LOW, {tag, " R6 low length"}, w, LOW);
        check(drive_en && drive_val && !reply_done, {tag, " R7 speedup"},
              {drive_en, drive_val, reply_done}, 3'b110);
        @(negedge clk);
        check(!drive_en && reply_done, {tag, " R8 release+done"},
              {drive_en, reply_done}, 2'b01);
        @(negedge clk);
        check(!drive_en && !reply_done, {tag, " R8 done single"},
              {drive_en, reply_done}, 2'b00);
    endtask

    task automatic t_reset();
        check(!drive_en && !drive_val && !reply_done, "R1 in reset",
              {drive_en, drive_val, reply_done}, 0);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        check(!drive_en && !drive_val && !reply_done, "R1 after reset",
              {drive_en, drive_val, reply_done}, 0);
    endtask

    task automatic t_short_run();
        hold_low(DET - 1);
        expect_quiet(60, "R2 short run ignored");
    endtask

    task automatic t_exact_run();
        hold_low(DET);
        measure_reply("R3 exact threshold");
        expect_quiet(20, "R3 idle after reply");
    endtask

    task automatic t_long_hold();
        bit ok = 1'b1;
        host_low = 1'b1;
        for (int i = 0; i < 3 * DET; i++) begin
            @(negedge clk);
            if (drive_en) ok = 1'b0;
        end
        check(ok, "R4 no drive while held low", ok, 1);
        host_low = 1'b0;
        measure_reply("R4 long hold");
    endtask

    task automatic t_split_runs();
        hold_low(DET - 1);
        @(negedge clk);
        hold_low(DET - 1);
        expect_quiet(60, "R9 split runs ignored");
    endtask

    task automatic t_abort_mid();
        hold_low(DET + 10);
        repeat (5) @(negedge clk);
        hold_low(3);
        expect_quiet(60, "R10 abort mid guard");
        hold_low(DET);
        measure_reply("R10 fresh request after abort");
    endtask

    task automatic t_abort_last();
        hold_low(DET + 4);
        repeat (GRD) @(negedge clk);
        hold_low(1);
        check(!drive_en, "R10 abort on last guard cycle", drive_en, 0);
        expect_quiet(60, "R10 no reply after late abort");
    endtask

    task automatic t_reset_mid();
        hold_low(DET);
        repeat (GRD + 30) @(negedge clk);
        check(drive_en && !drive_val, "R11 driving before reset", drive_en, 1);
        rst_n = 1'b0;
        #1;
        check(!drive_en && !reply_done, "R11 async release", drive_en, 0);
        @(negedge clk); rst_n = 1'b1;
        expect_quiet(60, "R11 no reply after reset");
    endtask

    initial begin
        t_reset();
        t_short_run();
        t_exact_run();
        t_long_hold();
        t_split_runs();
        t_abort_mid();
        t_abort_last();
        t_reset_mid();
        if (!finished) begin
            finished = 1'b1;
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end
endmodule